// File: doc/BRIEF.md
# Nine-Bit Multidrop Message Transmitter

This block queues whole messages of 8-bit bytes and hands them, one byte at a time, to an attached 9-bit UART transmitter. The ninth bit of every byte carries the frame boundary. It is 1 (mark) on the opening byte of a message and 0 (space) on every byte that follows. A writer announces a message with a start strobe and its length. The block admits the message only when the circular buffer has room for all of it. The writer then supplies the bytes as valid beats. Bytes go out in order, with their contents unchanged.

The ninth-bit output is a setting that the UART applies to whatever it shifts next. The block therefore changes it only while the UART reports its transmit path completely empty. When the next byte needs the other ninth-bit value, the block stops pushing bytes and waits for that empty indication. It then updates the setting, and only after that issues the byte. A status output tells the writer when a message of the configured maximum size would fit.

Top module: `nb_msg_tx`

## Requirements
- R1: On a `wr_start` pulse while no message is being collected, `wr_accept` is high in the same cycle exactly when 1 <= `wr_len` <= free space, where free space is DEPTH minus the bytes stored and not yet issued. Otherwise `wr_refuse` is high, and nothing is queued.
- R2: The first byte of each accepted message is issued with `tx_ninth` = 1. Every later byte of that message is issued with `tx_ninth` = 0.
- R3: Bytes are issued unaltered, in the order they were written, and messages are issued in the order they were accepted. This holds across wrap of the circular buffer.
- R4: `tx_push` is high only while at least one byte is stored and `tx_full` is low. It stays low once the buffer has drained.
- R5: `tx_ninth` changes only at a clock edge where `tx_empty` was high. While the next byte's ninth bit differs from `tx_ninth`, no byte is pushed.
- R6: After reset the applied ninth bit counts as unknown. The first byte is therefore not pushed until `tx_empty` has been seen high, whatever its ninth bit is.
- R7: `space_ok` is high exactly when DEPTH minus the stored bytes minus the bytes still owed by the message being collected is at least MAX_MSG.
- R8: After reset `tx_push`, `wr_accept` and `wr_refuse` are low, and `space_ok` is high.
- R9: A `wr_start` during collection of an accepted message raises neither `wr_accept` nor `wr_refuse`. Data beats that arrive while no accepted message is being collected are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_start | input | 1 | Start-of-message strobe, qualified by `wr_len` |
| wr_len | input | $clog2(DEPTH)+1 | Length in bytes of the announced message |
| wr_valid | input | 1 | Data beat valid |
| wr_data | input | 8 | Message byte |
| wr_accept | output | 1 | Message admitted (same cycle as `wr_start`) |
| wr_refuse | output | 1 | Message rejected (same cycle as `wr_start`) |
| space_ok | output | 1 | Room for a maximum-size message |
| tx_full | input | 1 | UART cannot take another byte |
| tx_empty | input | 1 | UART holding and shift stages empty; must be low in the cycle after a push |
| tx_push | output | 1 | Byte write strobe to the UART |
| tx_data | output | 8 | Byte presented to the UART |
| tx_ninth | output | 1 | Ninth-bit setting applied by the UART |

## Verification
The bench stalls the UART model with its empty flag held low, loads mark and space bytes, and expects no push at all. A design that trusted the reset value of the ninth bit, or that pushed on ready alone, would leak the first byte. The admission and space status are swept over every fill level, including an exact fit and a refused message whose beats are still driven. A design that wrote those beats would corrupt the later stream. The bench also runs back-to-back one-byte messages, mark followed by mark, and messages that straddle the buffer wrap. There, a wrong pointer or tag lookup shows up as a wrong byte or ninth bit against the bench's queue. It also checks that no ninth-bit change happens without a preceding empty indication.

// File: rtl/nb_msg_tx_pkg.sv
package nb_msg_tx_pkg;
  typedef enum logic {
    WS_IDLE    = 1'b0,
    WS_COLLECT = 1'b1
  } wr_state_t;
endpackage

// File: rtl/nb_msg_wr_ctrl.sv
module nb_msg_wr_ctrl
  import nb_msg_tx_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int MAX_MSG = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_start,
  input  logic [$clog2(DEPTH):0]  wr_len,
  input  logic                    wr_valid,
  input  logic [7:0]              wr_data,
  input  logic [$clog2(DEPTH):0]  rd_ptr,
  output logic                    wr_accept,
  output logic                    wr_refuse,
  output logic                    space_ok,
  output logic                    mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_waddr,
  output logic [7:0]              mem_wdata,
  output logic                    mem_wflag,
  output logic [$clog2(DEPTH):0]  wr_ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW:0] DEPTH_V = (CW+1)'(DEPTH);
  localparam logic [CW:0] MAXM_V  = (CW+1)'(MAX_MSG);

  wr_state_t      state_q, state_d;
  logic [CW-1:0]  wp_q, wp_d;
  logic [CW-1:0]  remain_q, remain_d;
  logic           first_q, first_d;
  logic [CW-1:0]  used;
  logic [CW:0]    free;
  logic           idle, upd_en;

  assign idle = (state_q == WS_IDLE);
  assign used = wp_q - rd_ptr;
  assign free = DEPTH_V - {1'b0, used} - {1'b0, remain_q};

  assign wr_accept = wr_start && idle && (wr_len != '0) && ({1'b0, wr_len} <= free);
  assign wr_refuse = wr_start && idle && !wr_accept;
  assign space_ok  = (free >= MAXM_V);

  assign mem_we    = !idle && wr_valid;
  assign mem_waddr = wp_q[AW-1:0];
  assign mem_wdata = wr_data;
  assign mem_wflag = first_q;
  assign wr_ptr    = wp_q;
  assign upd_en    = wr_accept || mem_we;

  always_comb begin
    state_d  = state_q;
    wp_d     = wp_q;
    remain_d = remain_q;
    first_d  = first_q;
    if (wr_accept) begin
      state_d  = WS_COLLECT;
      remain_d = wr_len;
      first_d  = 1'b1;
    end else if (mem_we) begin
      wp_d     = wp_q + 1'b1;
      remain_d = remain_q - 1'b1;
      first_d  = 1'b0;
      if (remain_q == CW'(1)) state_d = WS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      wp_q     <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      wp_q     <= wp_d;
      remain_q <= remain_d;
      first_q  <= first_d;
    end
  end

  // R1: stored plus reserved bytes never exceed the buffer
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, used} + {1'b0, remain_q}) <= DEPTH_V);
endmodule

// File: rtl/nb_msg_store.sv
module nb_msg_store #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic                     wflag,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata,
  output logic                     rflag
);
  logic [7:0] byte_mem [DEPTH];
  logic       flag_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      byte_mem[waddr] <= wdata;
      flag_mem[waddr] <= wflag;
    end
  end

  assign rdata = byte_mem[raddr];
  assign rflag = flag_mem[raddr];
endmodule

// File: rtl/nb_msg_issue.sv
module nb_msg_issue #(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(DEPTH):0] wr_ptr,
  input  logic                   head_flag,
  input  logic                   tx_full,
  input  logic                   tx_empty,
  output logic [$clog2(DEPTH):0] rd_ptr,
  output logic                   tx_push,
  output logic                   tx_ninth
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] rp_q, rp_d;
  logic          ninth_q, ninth_d;
  logic          known_q, known_d;
  logic          have, match, set_ninth, upd_en;

  assign have      = (wr_ptr != rp_q);
  assign match     = known_q && (head_flag == ninth_q);
  assign tx_push   = have && match && !tx_full;
  assign set_ninth = have && !match && tx_empty;
  assign upd_en    = tx_push || set_ninth;

  always_comb begin
    rp_d    = rp_q;
    ninth_d = ninth_q;
    known_d = known_q;
    if (tx_push) rp_d = rp_q + 1'b1;
    if (set_ninth) begin
      ninth_d = head_flag;
      known_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q    <= '0;
      ninth_q <= 1'b0;
      known_q <= 1'b0;
    end else if (upd_en) begin
      rp_q    <= rp_d;
      ninth_q <= ninth_d;
      known_q <= known_d;
    end
  end

  assign rd_ptr   = rp_q;
  assign tx_ninth = ninth_q;

  // R5: ninth-bit setting moves only after an empty indication
  assert_ninth_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ninth_q) |-> $past(tx_empty));
  // R6: the first ninth-bit application after reset waits for empty
  assert_first_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(known_q) |-> $past(tx_empty));
  // R3: read pointer advances by one, only on a push
  assert_rdptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rp_q) |-> ($past(tx_push) && (rp_q == $past(rp_q) + 1'b1)));
endmodule

// File: rtl/nb_msg_tx.sv
module nb_msg_tx #(
  parameter int DEPTH   = 16,
  parameter int MAX_MSG = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_start,
  input  logic [$clog2(DEPTH):0] wr_len,
  input  logic                   wr_valid,
  input  logic [7:0]             wr_data,
  output logic                   wr_accept,
  output logic                   wr_refuse,
  output logic                   space_ok,
  input  logic                   tx_full,
  input  logic                   tx_empty,
  output logic                   tx_push,
  output logic [7:0]             tx_data,
  output logic                   tx_ninth
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          mem_we, mem_wflag, head_flag;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [CW-1:0] wr_ptr, rd_ptr, used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  nb_msg_wr_ctrl #(.DEPTH(DEPTH), .MAX_MSG(MAX_MSG)) u_wr (
    .clk(clk), .rst_n(rst_core_n),
    .wr_start(wr_start), .wr_len(wr_len), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_ptr(rd_ptr),
    .wr_accept(wr_accept), .wr_refuse(wr_refuse), .space_ok(space_ok),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_wflag(mem_wflag), .wr_ptr(wr_ptr)
  );

  nb_msg_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata), .wflag(mem_wflag),
    .raddr(rd_ptr[AW-1:0]), .rdata(tx_data), .rflag(head_flag)
  );

  nb_msg_issue #(.DEPTH(DEPTH)) u_issue (
    .clk(clk), .rst_n(rst_core_n),
    .wr_ptr(wr_ptr), .head_flag(head_flag),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rd_ptr(rd_ptr), .tx_push(tx_push), .tx_ninth(tx_ninth)
  );

  assign used = wr_ptr - rd_ptr;

  // R3: reader never passes writer, writer never laps reader
  assert_ptr_order_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    {1'b0, used} <= (CW+1)'(DEPTH));
  // R4: pushing the last stored byte with no refill ends the push stream
  assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_push && (used == CW'(1)) && !mem_we) |=> !tx_push);
  // R4: no push toward a full transmitter
  assert_push_room_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_push |-> !tx_full);
endmodule

// File: tb/nb_msg_tx_tb.sv
module nb_msg_tx_tb;
  localparam int DEPTH = 16;
  localparam int MAXM  = 6;
  localparam int CAP   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_start = 1'b0;
  logic [4:0] wr_len = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_accept, wr_refuse, space_ok, tx_push, tx_ninth;
  logic [7:0] tx_data;
  logic       tx_full, tx_empty;

  int occ = 0;
  bit hold_low = 1'b1;
  bit drain_en = 1'b0;
  int tick = 0;

  int checks = 0, fails = 0, npush = 0, cyc = 0;
  bit done = 1'b0, mon_on = 1'b0;
  logic [8:0] expq[$];
  logic prev_ninth, prev_empty;

  always #2 clk = ~clk;

  assign tx_full  = (occ == CAP);
  assign tx_empty = (occ == 0) && !hold_low;

  nb_msg_tx #(.DEPTH(DEPTH), .MAX_MSG(MAXM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_len(wr_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_accept(wr_accept),
    .wr_refuse(wr_refuse), .space_ok(space_ok), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_push(tx_push), .tx_data(tx_data), .tx_ninth(tx_ninth)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 29 + k * 13 + 7) & 255);
  endfunction

  // UART model: holding occupancy, drains one byte every 3 cycles when enabled
  always @(posedge clk) begin
    int dec;
    dec = 0;
    if (drain_en) begin
      tick = (tick + 1) % 3;
      if (tick == 0 && occ > 0) dec = 1;
    end
    occ <= occ + (tx_push ? 1 : 0) - dec;
  end

  // Output monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_ninth != prev_ninth)
        chk(prev_empty, "R5 ninth changed without empty", int'(prev_empty), 1);
      if (tx_push) begin
        npush++;
        chk(!tx_full, "R4 push while full", int'(tx_full), 0);
        if (expq.size() == 0) chk(1'b0, "R3 unexpected byte", int'({tx_ninth, tx_data}), -1);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk(e[7:0] == tx_data, "R3 byte value/order", int'(tx_data), int'(e[7:0]));
          chk(e[8] == tx_ninth, "R2 ninth bit", int'(tx_ninth), int'(e[8]));
        end
      end
    end
    prev_ninth = tx_ninth;
    prev_empty = tx_empty;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input int len, input int seed, input int exp_acc,
                      input bit beats_anyway, output bit acc);
    @(negedge clk);
    wr_start = 1'b1; wr_len = 5'(len);
    #1;
    acc = wr_accept;
    chk(wr_accept ^ wr_refuse, "R1 exactly one of accept/refuse", int'({wr_accept, wr_refuse}), 1);
    if (exp_acc >= 0) chk(int'(acc) == exp_acc, "R1 admission", int'(acc), exp_acc);
    @(negedge clk);
    wr_start = 1'b0;
    if (acc || beats_anyway) begin
      for (int k = 0; k < len; k++) begin
        wr_valid = 1'b1; wr_data = pat(seed, k);
        if (acc) expq.push_back({(k == 0), pat(seed, k)});
        @(negedge clk);
      end
      wr_valid = 1'b0;
    end
  endtask

  task automatic wait_drain(input string req);
    int g;
    g = 0;
    while ((expq.size() != 0 || occ != 0) && g < 5000) begin
      @(negedge clk); g++;
    end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    bit acc;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    prev_ninth = tx_ninth; prev_empty = tx_empty;
    mon_on = 1'b1;
    // R8 reset state
    chk(!tx_push, "R8 tx_push after reset", int'(tx_push), 0);
    chk(!wr_accept && !wr_refuse, "R8 accept/refuse after reset", int'({wr_accept, wr_refuse}), 0);
    chk(space_ok, "R8 space_ok after reset", int'(space_ok), 1);

    // Stalled UART: empty held low, not full. R6: nothing may go out.
    send(5, 1, 1, 0, acc);
    chk(space_ok, "R7 free 11", int'(space_ok), 1);
    send(0, 2, 0, 0, acc);                 // R1 zero length
    send(12, 3, 0, 1, acc);                // R1 too long; R9 beats discarded
    chk(space_ok, "R9 refused beats left space", int'(space_ok), 1);
    // exact fit of 11 with a stray start mid-collection (R9)
    @(negedge clk);
    wr_start = 1'b1; wr_len = 5'd11; #1;
    chk(wr_accept, "R1 exact fit", int'(wr_accept), 1);
    @(negedge clk);
    wr_start = 1'b0;
    for (int k = 0; k < 11; k++) begin
      wr_valid = 1'b1; wr_data = pat(4, k);
      expq.push_back({(k == 0), pat(4, k)});
      if (k == 3) begin
        wr_start = 1'b1; wr_len = 5'd1; #1;
        chk(!wr_accept && !wr_refuse, "R9 start during collection", int'({wr_accept, wr_refuse}), 0);
        chk(!space_ok, "R7 owed bytes count against space", int'(space_ok), 0);
      end
      @(negedge clk);
      wr_start = 1'b0;
    end
    wr_valid = 1'b0;
    send(1, 5, 0, 0, acc);                 // R1 full buffer
    repeat (20) @(negedge clk);
    chk(npush == 0, "R6 no push before empty seen", npush, 0);

    hold_low = 1'b0; drain_en = 1'b1;
    wait_drain("R3 first batch drained");
    chk(npush == 16, "R3 byte count", npush, 16);
    p0 = npush;
    repeat (10) @(negedge clk);
    chk(npush == p0 && !tx_push, "R4 no push once drained", npush - p0, 0);
    chk(space_ok, "R7 empty buffer", int'(space_ok), 1);

    // Sweep every length, buffer drained between messages; wraps vary
    for (int len = 1; len <= DEPTH; len++) begin
      send(len, 10 + len, 1, 0, acc);
      wait_drain("R3 sweep message");
    end

    // Fill-level sweep with UART stalled: 16 one-byte messages
    hold_low = 1'b1; drain_en = 1'b0;
    p0 = npush;
    for (int n = 1; n <= DEPTH; n++) begin
      send(1, 40 + n, 1, 0, acc);
      chk(space_ok == ((DEPTH - n) >= MAXM), "R7 space level", int'(space_ok),
          int'((DEPTH - n) >= MAXM));
    end
    send(1, 60, 0, 0, acc);
    chk(npush == p0, "R5 no push while ninth change pending", npush - p0, 0);
    hold_low = 1'b0; drain_en = 1'b1;
    wait_drain("R2 back-to-back marks drained");

    // Overlapped traffic with the UART draining
    for (int i = 0; i < 60; i++) begin
      send((i % 7) + 1, 100 + i, -1, 0, acc);
      if (i % 10 == 9) begin
        send(1, 200 + i, -1, 0, acc);
        send(1, 300 + i, -1, 0, acc);
      end
    end
    wait_drain("R3 overlapped traffic drained");
    p0 = npush;
    repeat (10) @(negedge clk);
    chk(npush == p0 && !tx_push, "R4 quiet at end", npush - p0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule